// File: doc/BRIEF.md
# Single-Block Dirty Victim Buffer

This block sits beside a write-back, direct-mapped second-level cache and parks one evicted dirty block so that the refill of the missing line can use the memory path first. The cache controller offers each victim on an evict port together with a dirty flag. A clean victim is dropped on the spot. A dirty victim is copied, with its block address, into a single 32-byte holding register. The buffer then waits until the controller reports that the refill has been installed. Only after that report does it write the victim to memory as two 16-byte beats over a valid/ready write port.

While the buffer is occupied, a further dirty eviction cannot be taken and the block raises a stall until the drain has completed. Clean evictions never stall. The controller may also compare a block address against the parked victim. On a match it reads the block from the buffer, which covers a re-reference to the victim before it has reached memory.

Top module: `victim_buffer`

## Requirements
- R1: After reset the buffer is empty: `evict_stall`, `mem_wvalid` and `lookup_hit` are all 0.
- R2: A dirty eviction (`evict_valid`=1, `evict_dirty`=1) offered while the buffer is empty is captured at that clock edge. From the next cycle on, `lookup_hit` is 1 for its address and `lookup_data` equals its data.
- R3: A clean eviction (`evict_dirty`=0) is discarded. It never raises `evict_stall`, it leaves the buffer empty (`lookup_hit` stays 0) and it causes no memory write.
- R4: A captured victim is not written while the refill is still pending: `mem_wvalid` stays 0 until `refill_done` has been sampled high with the buffer occupied.
- R5: `mem_wvalid` rises in the cycle after the edge that samples `refill_done`=1 with a victim parked.
- R6: The victim drains as two beats carrying the victim's block address on `mem_waddr`. Beat 0 (`mem_wbeat`=0) carries data bits 127:0 and beat 1 (`mem_wbeat`=1) carries bits 255:128. A beat is consumed at each edge where `mem_wvalid` and `mem_wready` are both 1.
- R7: While `mem_wvalid`=1 and `mem_wready`=0, address, beat index and data hold unchanged into the next cycle.
- R8: `evict_stall` is 1 exactly when a dirty eviction is offered while the buffer is occupied. A stalled eviction is not captured, and the parked victim is unchanged.
- R9: In the cycle after the edge that accepts beat 1, the buffer is empty again: `mem_wvalid`=0, `lookup_hit`=0, and a new dirty eviction is accepted without stall.
- R10: `lookup_hit` is 0 whenever `lookup_addr` differs from the parked address or the buffer is empty.
- R11: `refill_done` has no effect while the buffer is empty or already draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_valid | input | 1 | Controller offers a victim this cycle |
| evict_dirty | input | 1 | Offered victim was modified |
| evict_addr | input | ADDR_W | Block address of the victim |
| evict_data | input | 256 | Victim block contents |
| evict_stall | output | 1 | Dirty victim cannot be taken; controller must hold the miss |
| refill_done | input | 1 | Refill data for the miss has been installed |
| lookup_addr | input | ADDR_W | Block address probed against the buffer |
| lookup_hit | output | 1 | Probe matches the parked victim |
| lookup_data | output | 256 | Parked block, meaningful when `lookup_hit`=1 |
| mem_wvalid | output | 1 | Write beat offered to memory |
| mem_wready | input | 1 | Memory accepts the beat |
| mem_waddr | output | ADDR_W | Block address of the write |
| mem_wbeat | output | 1 | Index of the beat being offered |
| mem_wdata | output | 128 | Beat data |

## Verification
`evict_stall` and `lookup_hit`/`lookup_data` are combinational. They are due in the same cycle as the inputs that cause them. A capture shows up in the lookup one cycle after the accepting edge. `mem_wvalid` rises one cycle after the edge that samples `refill_done`. Each beat, and the return to empty, takes effect one cycle after the edge that accepts a beat. The bench drives inputs 1 ns after a rising edge and compares every output 1 ns later against a reference model of the requirements. It advances that model only at the following edge, so each output is compared in the cycle in which it is due.

// File: rtl/vb_pkg.sv
package vb_pkg;
  typedef enum logic [1:0] {
    VB_EMPTY = 2'd0,
    VB_HOLD  = 2'd1,
    VB_DRAIN = 2'd2
  } vb_state_e;
endpackage

// File: rtl/vb_ctrl.sv
module vb_ctrl #(
  parameter int BEATS = 2,
  parameter int CNT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evict_valid,
  input  logic             evict_dirty,
  input  logic             refill_done,
  input  logic             mem_wready,
  output logic             capture,
  output logic             occupied,
  output logic             draining,
  output logic             stall,
  output logic [CNT_W-1:0] beat
);
  import vb_pkg::*;

  vb_state_e        state_q, state_d;
  logic [CNT_W-1:0] beat_q, beat_d;
  logic             last_beat;

  assign last_beat = (beat_q == CNT_W'(BEATS - 1));

  // next-state
  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    capture = 1'b0;
    unique case (state_q)
      VB_EMPTY: begin
        if (evict_valid && evict_dirty) begin
          capture = 1'b1;
          state_d = VB_HOLD;
        end
      end
      VB_HOLD: begin
        // victim waits until the refill has been installed
        if (refill_done) begin
          state_d = VB_DRAIN;
          beat_d  = '0;
        end
      end
      VB_DRAIN: begin
        if (mem_wready) begin
          if (last_beat) begin
            state_d = VB_EMPTY;
            beat_d  = '0;
          end else begin
            beat_d = beat_q + CNT_W'(1);
          end
        end
      end
      default: state_d = VB_EMPTY;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VB_EMPTY;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign occupied = (state_q != VB_EMPTY);
  assign draining = (state_q == VB_DRAIN);
  assign stall    = occupied && evict_valid && evict_dirty;
  assign beat     = beat_q;
endmodule

// File: rtl/vb_store.sv
module vb_store #(
  parameter int ADDR_W  = 26,
  parameter int BLOCK_W = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic               occupied,
  input  logic [ADDR_W-1:0]  evict_addr,
  input  logic [BLOCK_W-1:0] evict_data,
  input  logic [ADDR_W-1:0]  lookup_addr,
  output logic               lookup_hit,
  output logic [ADDR_W-1:0]  buf_addr,
  output logic [BLOCK_W-1:0] buf_data
);
  logic [ADDR_W-1:0]  addr_q;
  logic [BLOCK_W-1:0] data_q;

  // tag register, reset so the probe compare is defined
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (capture) begin
      addr_q <= evict_addr;
    end
  end

  // data register, enable only
  always_ff @(posedge clk) begin
    if (capture) begin
      data_q <= evict_data;
    end
  end

  assign lookup_hit = occupied && (lookup_addr == addr_q);
  assign buf_addr   = addr_q;
  assign buf_data   = data_q;
endmodule

// File: rtl/vb_beat_sel.sv
module vb_beat_sel #(
  parameter int BEAT_W = 128,
  parameter int BEATS  = 2,
  parameter int CNT_W  = 1
) (
  input  logic [BEAT_W*BEATS-1:0] block,
  input  logic [CNT_W-1:0]        sel,
  output logic [BEAT_W-1:0]       beat_data
);
  logic [BEAT_W-1:0] slice [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_slice
    assign slice[g] = block[g*BEAT_W +: BEAT_W];
  end

  always_comb begin
    beat_data = slice[0];
    for (int i = 0; i < BEATS; i++) begin
      if (sel == CNT_W'(i)) beat_data = slice[i];
    end
  end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int  ADDR_W      = 26,
  parameter int  BLOCK_BYTES = 32,
  parameter int  BEAT_BYTES  = 16,
  localparam int BLOCK_W     = BLOCK_BYTES * 8,
  localparam int BEAT_W      = BEAT_BYTES * 8,
  localparam int BEATS       = BLOCK_BYTES / BEAT_BYTES,
  localparam int CNT_W       = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evict_valid,
  input  logic               evict_dirty,
  input  logic [ADDR_W-1:0]  evict_addr,
  input  logic [BLOCK_W-1:0] evict_data,
  output logic               evict_stall,
  input  logic               refill_done,
  input  logic [ADDR_W-1:0]  lookup_addr,
  output logic               lookup_hit,
  output logic [BLOCK_W-1:0] lookup_data,
  output logic               mem_wvalid,
  input  logic               mem_wready,
  output logic [ADDR_W-1:0]  mem_waddr,
  output logic [CNT_W-1:0]   mem_wbeat,
  output logic [BEAT_W-1:0]  mem_wdata
);
  logic               capture;
  logic               occupied;
  logic               draining;
  logic [CNT_W-1:0]   beat;
  logic [ADDR_W-1:0]  buf_addr;
  logic [BLOCK_W-1:0] buf_data;

  vb_ctrl #(.BEATS(BEATS), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .evict_valid (evict_valid),
    .evict_dirty (evict_dirty),
    .refill_done (refill_done),
    .mem_wready  (mem_wready),
    .capture     (capture),
    .occupied    (occupied),
    .draining    (draining),
    .stall       (evict_stall),
    .beat        (beat)
  );

  vb_store #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (capture),
    .occupied    (occupied),
    .evict_addr  (evict_addr),
    .evict_data  (evict_data),
    .lookup_addr (lookup_addr),
    .lookup_hit  (lookup_hit),
    .buf_addr    (buf_addr),
    .buf_data    (buf_data)
  );

  vb_beat_sel #(.BEAT_W(BEAT_W), .BEATS(BEATS), .CNT_W(CNT_W)) u_sel (
    .block     (buf_data),
    .sel       (beat),
    .beat_data (mem_wdata)
  );

  assign lookup_data = buf_data;
  assign mem_wvalid  = draining;
  assign mem_waddr   = buf_addr;
  assign mem_wbeat   = beat;
endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
  parameter int ADDR_W = 26,
  parameter int BEAT_W = 128,
  parameter int BEATS  = 2,
  parameter int CNT_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evict_valid,
  input logic              evict_dirty,
  input logic              evict_stall,
  input logic              refill_done,
  input logic              mem_wvalid,
  input logic              mem_wready,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic [CNT_W-1:0]  mem_wbeat,
  input logic [BEAT_W-1:0] mem_wdata,
  input logic              occupied,
  input logic [ADDR_W-1:0] buf_addr
);
  p_clean_no_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && !evict_dirty && !occupied && !refill_done) |=> !occupied);

  p_write_needs_victim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> occupied);

  p_drain_after_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wvalid) |-> $past(refill_done));

  p_hold_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wready) |=>
      (mem_wvalid && $stable(mem_wdata) && $stable(mem_wbeat) && $stable(mem_waddr)));

  p_stall_keeps_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evict_stall |=> $stable(buf_addr));

  p_last_beat_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && mem_wready && (mem_wbeat == CNT_W'(BEATS - 1))) |=> !occupied);
endmodule

bind victim_buffer vb_checker #(
  .ADDR_W (ADDR_W),
  .BEAT_W (BEAT_W),
  .BEATS  (BEATS),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evict_valid (evict_valid),
  .evict_dirty (evict_dirty),
  .evict_stall (evict_stall),
  .refill_done (refill_done),
  .mem_wvalid  (mem_wvalid),
  .mem_wready  (mem_wready),
  .mem_waddr   (mem_waddr),
  .mem_wbeat   (mem_wbeat),
  .mem_wdata   (mem_wdata),
  .occupied    (occupied),
  .buf_addr    (buf_addr)
);

// File: tb/victim_buffer_tb.sv
`timescale 1ns/1ps
module victim_buffer_tb;
  localparam int AW = 26;

  logic           clk;
  logic           rst_n;
  logic           evict_valid, evict_dirty, refill_done, mem_wready;
  logic [AW-1:0]  evict_addr, lookup_addr;
  logic [255:0]   evict_data;
  logic           evict_stall, lookup_hit, mem_wvalid;
  logic [255:0]   lookup_data;
  logic [AW-1:0]  mem_waddr;
  logic [0:0]     mem_wbeat;
  logic [127:0]   mem_wdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model state
  bit             m_occ, m_drain;
  bit             m_beat;
  logic [AW-1:0]  m_addr;
  logic [255:0]   m_data;

  victim_buffer u_dut (
    .clk(clk), .rst_n(rst_n),
    .evict_valid(evict_valid), .evict_dirty(evict_dirty),
    .evict_addr(evict_addr), .evict_data(evict_data),
    .evict_stall(evict_stall), .refill_done(refill_done),
    .lookup_addr(lookup_addr), .lookup_hit(lookup_hit), .lookup_data(lookup_data),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
    .mem_waddr(mem_waddr), .mem_wbeat(mem_wbeat), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd_block();
    logic [255:0] b;
    for (int i = 0; i < 8; i++) b[i*32 +: 32] = $urandom;
    return b;
  endfunction

  function automatic bit exp_stall(bit ev, bit dirty);
    return m_occ && ev && dirty;
  endfunction

  function automatic bit exp_hit(logic [AW-1:0] la);
    return m_occ && (la == m_addr);
  endfunction

  function automatic logic [127:0] exp_beat();
    return m_beat ? m_data[255:128] : m_data[127:0];
  endfunction

  // one cycle: drive at edge+1, check at edge+2, advance model at next edge
  task automatic cyc(input bit ev, input bit dirty, input logic [AW-1:0] a,
                     input logic [255:0] d, input bit rf, input logic [AW-1:0] la,
                     input bit wr);
    evict_valid = ev; evict_dirty = dirty; evict_addr = a; evict_data = d;
    refill_done = rf; lookup_addr = la; mem_wready = wr;
    #1;
    chk(evict_stall == exp_stall(ev, dirty), "R8 R9 R3 stall",
        256'(evict_stall), 256'(exp_stall(ev, dirty)));
    chk(lookup_hit == exp_hit(la), "R2 R3 R10 lookup_hit",
        256'(lookup_hit), 256'(exp_hit(la)));
    if (exp_hit(la))
      chk(lookup_data == m_data, "R2 lookup_data", lookup_data, m_data);
    chk(mem_wvalid == m_drain, "R4 R5 R9 R11 mem_wvalid",
        256'(mem_wvalid), 256'(m_drain));
    if (m_drain) begin
      chk(mem_wbeat == m_beat, "R6 R7 beat index", 256'(mem_wbeat), 256'(m_beat));
      chk(mem_waddr == m_addr, "R6 R7 address", 256'(mem_waddr), 256'(m_addr));
      chk(mem_wdata == exp_beat(), "R6 R7 beat data", 256'(mem_wdata), 256'(exp_beat()));
    end
    @(posedge clk);
    if (!m_occ) begin
      if (ev && dirty) begin
        m_occ = 1; m_addr = a; m_data = d;
      end
    end else if (!m_drain) begin
      if (rf) begin
        m_drain = 1; m_beat = 0;
      end
    end else if (wr) begin
      if (m_beat) begin
        m_occ = 0; m_drain = 0; m_beat = 0;
      end else begin
        m_beat = 1;
      end
    end
    #1;
  endtask

  initial begin
    automatic logic [255:0] d1 = rnd_block();
    automatic logic [255:0] d2 = rnd_block();
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0;
    evict_valid = 0; evict_dirty = 0; evict_addr = '0; evict_data = '0;
    refill_done = 0; lookup_addr = '0; mem_wready = 0;
    m_occ = 0; m_drain = 0; m_beat = 0; m_addr = '0; m_data = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(!evict_stall && !mem_wvalid && !lookup_hit, "R1 reset outputs",
        {253'd0, evict_stall, mem_wvalid, lookup_hit}, 256'd0);
    @(posedge clk); #1;

    // directed corner cases
    cyc(1, 0, 26'h0000abc, d1, 0, 26'h0000abc, 1); // R3 clean victim dropped
    cyc(0, 0, '0, '0, 1, 26'h0000abc, 1);         // R11 refill while empty
    cyc(0, 0, '0, '0, 0, 26'h0000abc, 1);         // R3 still empty, no write
    cyc(1, 1, 26'h0000abc, d1, 0, 26'h0000001, 1); // R2 capture
    cyc(1, 1, 26'h0000def, d2, 0, 26'h0000abc, 1); // R8 stall, R2 hit
    cyc(1, 0, 26'h0000def, d2, 0, 26'h0000def, 1); // R3 clean never stalls, R10
    cyc(0, 0, '0, '0, 0, 26'h0000abc, 1);         // R4 waiting for refill
    cyc(0, 0, '0, '0, 1, 26'h0000abc, 0);         // R5 refill installed
    cyc(1, 1, 26'h0000def, d2, 1, 26'h0000abc, 0); // R7 beat 0 held, R11
    cyc(0, 0, '0, '0, 0, 26'h0000abc, 0);         // R7 held again
    cyc(0, 0, '0, '0, 0, 26'h0000abc, 1);         // R6 beat 0 taken
    cyc(0, 0, '0, '0, 0, 26'h0000abc, 1);         // R6 beat 1 taken
    cyc(1, 1, 26'h0000def, d2, 0, 26'h0000abc, 1); // R9 empty, accepts new
    cyc(0, 0, '0, '0, 0, 26'h0000def, 1);         // R2 new victim parked

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      automatic bit ev    = ($urandom_range(0, 3) != 0);
      automatic bit dirty = ($urandom_range(0, 2) != 0);
      automatic logic [AW-1:0] a  = AW'($urandom);
      automatic logic [AW-1:0] la = ($urandom_range(0, 1) != 0) ? m_addr : AW'($urandom);
      automatic bit rf    = ($urandom_range(0, 3) == 0);
      automatic bit wr    = ($urandom_range(0, 2) != 0);
      cyc(ev, dirty, a, rnd_block(), rf, la, wr);
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // watchdog
  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule